// File: doc/BRIEF.md
# SM4 Iterative Block Encryption Core

This core encrypts one 128-bit block with the SM4 cipher. It runs one round per clock and takes 32 rounds per block. A start strobe on an idle core captures the plaintext. The core then reads one 32-bit round key per round through an indexed read port. The index it drives on that port is the current round number, and the key must come back combinationally in the same cycle. Key expansion is done outside the core, so a key store or a separate schedule engine sits behind the port.

The datapath holds the cipher state as four 32-bit words and shifts them once per round. The byte substitution uses four parallel byte S-box instances. Each instance builds the SM4 S-box from a 4-bit-indexed affine map, the AES multiplicative-inverse-and-affine core computed in logic, and a second 4-bit-indexed affine map. The diffusion step is computed in a factored form: byte rotations are combined, then rotated by two bits. When the last round has finished, the core raises a one-cycle done pulse. The ciphertext stays readable until the next block is started.

Top module: `sm4c_iter_core`

## Requirements
- R1: On an accepted start, plaintext bits [127:96] become state word 0, [95:64] word 1, [63:32] word 2 and [31:0] word 3. The byte order inside each word is big-endian (bits [31:24] are the most significant byte).
- R2: A block takes exactly 32 rounds. In the k-th clock cycle after the start edge (k = 0..31), the round-key index output equals k, and that cycle's key is used for round k.
- R3: The substitution input is state word 1 XOR word 2 XOR word 3 XOR the round key. Each of its four bytes passes independently through the SM4 S-box (for example, S-box(0x00) = 0xD6).
- R4: The diffusion of substitution output b equals b XOR b rotated left by 2, 10, 18 and 24 bits.
- R5: The new word is the diffusion output XOR state word 0. Words 1, 2 and 3 move down to positions 0, 1 and 2, and the new word becomes word 3.
- R6: The ciphertext output is {word 3, word 2, word 1, word 0} of the final state, so word 3 sits in bits [127:96].
- R7: done_o is high for exactly one cycle, in the cycle after the 32nd round edge. It is low otherwise.
- R8: A start strobe while a block is in progress, including during its last round, is ignored. The running block's result and timing are unchanged.
- R9: After done_o, the ciphertext output holds its value while the plaintext input changes, until a new start is accepted.
- R10: A synchronous active-high reset returns the core to idle with done_o low, a zero ciphertext output and a round-key index of 0. A block that was cut off by reset never raises done_o.
- R11: With key and plaintext 0123456789abcdeffedcba9876543210, and round keys expanded from that key, the ciphertext is 681edf34d206965e86b3e94f536e4246.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a block; honoured only when idle |
| plain_i | input | 128 | Plaintext, sampled on an accepted start |
| rk_idx_o | output | 5 | Index of the round key needed this cycle |
| rk_i | input | 32 | Round key for rk_idx_o, valid in the same cycle |
| cipher_o | output | 128 | Ciphertext, valid from done_o until the next start |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The standard vector and several other key and plaintext pairs are compared against an independent reference in the bench. That reference uses the unfactored five-term diffusion and its own S-box construction, so a wrong nibble table, a mis-factored diffusion, swapped output words or little-endian word loading shows up as a corrupted ciphertext. The round-key index is sampled in every round, and the done pulse is checked in the cycles around completion, so an off-by-one round count shows up as a wrong key order or a pulse one cycle early or late. A start pulse is injected in the middle of a block and again during the final round; a core that restarted would return the wrong ciphertext or move the pulse. A reset in the middle of a block must leave no pending done pulse behind.

// File: rtl/sm4c_pkg.sv
package sm4c_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int NWORDS  = 4;
    localparam int BLOCK_W = NWORDS * WORD_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // word 0 occupies the most significant position so a direct load
    // of the block gives big-endian word order
    typedef struct packed {
        word_t w0;
        word_t w1;
        word_t w2;
        word_t w3;
    } state_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;

    // 16-entry nibble maps, entry n at bits [8n+7:8n]
    localparam logic [127:0] PRE_LO  = 128'hC7C1B4B222245157_9197E2E474720701;
    localparam logic [127:0] PRE_HI  = 128'hF052B91BF95BB012_E240AB09EB49A200;
    localparam logic [127:0] POST_LO = 128'hEDD14478172BBE82_5B67F2CEA19D0834;
    localparam logic [127:0] POST_HI = 128'h11CDBE62CC1063BF_AE7201DD73AFDC00;

    function automatic byte_t nib_map(input logic [127:0] tbl, input logic [3:0] n);
        return tbl[{n, 3'b000} +: 8];
    endfunction

    // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
        end
        return acc;
    endfunction

    // x^254, which maps 0 to 0
    function automatic byte_t gf_inv(input byte_t x);
        byte_t r;
        byte_t s;
        r = 8'h01;
        s = x;
        for (int i = 0; i < 7; i++) begin
            s = gf_mul(s, s);
            r = gf_mul(r, s);
        end
        return r;
    endfunction

    function automatic byte_t rotl8(input byte_t b, input int n);
        return byte_t'((b << n) | (b >> (8 - n)));
    endfunction

    function automatic byte_t aes_core(input byte_t x);
        byte_t v;
        v = gf_inv(x);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    function automatic word_t rotl32(input word_t w, input int n);
        return word_t'((w << n) | (w >> (WORD_W - n)));
    endfunction

endpackage

// File: rtl/sm4c_sbox8.sv
module sm4c_sbox8
    import sm4c_pkg::*;
(
    input  logic [7:0] in_b,
    output logic [7:0] out_b
);
    byte_t pre;
    byte_t mid;

    always_comb begin
        pre   = nib_map(PRE_LO, in_b[3:0]) ^ nib_map(PRE_HI, in_b[7:4]);
        mid   = aes_core(pre);
        out_b = nib_map(POST_LO, mid[3:0]) ^ nib_map(POST_HI, mid[7:4]);
    end
endmodule

// File: rtl/sm4c_tau.sv
module sm4c_tau
    import sm4c_pkg::*;
#(
    parameter int W = WORD_W
)(
    input  logic [W-1:0] x_i,
    output logic [W-1:0] y_o
);
    localparam int NB = W / BYTE_W;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        sm4c_sbox8 u_sb (
            .in_b  (x_i[g*BYTE_W +: BYTE_W]),
            .out_b (y_o[g*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: rtl/sm4c_diffuse.sv
module sm4c_diffuse
    import sm4c_pkg::*;
(
    input  logic [WORD_W-1:0] b_i,
    output logic [WORD_W-1:0] c_o
);
    word_t mix;

    always_comb begin
        mix = b_i ^ rotl32(b_i, 8) ^ rotl32(b_i, 16);
        c_o = b_i ^ rotl32(mix, 2) ^ rotl32(b_i, 24);
    end
endmodule

// File: rtl/sm4c_seq.sv
module sm4c_seq
    import sm4c_pkg::*;
#(
    parameter int ROUNDS = 32,
    localparam int IDX_W = $clog2(ROUNDS)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             load_o,
    output logic             busy_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             done_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

    phase_t           phase;
    logic [IDX_W-1:0] cnt;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start_i) begin
                        phase <= PH_RUN;
                        cnt   <= '0;
                    end
                end
                PH_RUN: begin
                    if (cnt == LAST) begin
                        phase  <= PH_IDLE;
                        cnt    <= '0;
                        done_q <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign load_o = (phase == PH_IDLE) && start_i;
    assign busy_o = (phase == PH_RUN);
    assign idx_o  = cnt;
    assign done_o = done_q;

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && idx_o == LAST) |=> (done_o && !busy_o));

    p_idx_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (busy_o && idx_o != LAST) |=> (busy_o && idx_o == $past(idx_o) + 1'b1));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && idx_o != LAST) |=> (busy_o && !done_o));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> (!busy_o && idx_o == '0));
endmodule

// File: rtl/sm4c_iter_core.sv
module sm4c_iter_core
    import sm4c_pkg::*;
#(
    parameter int ROUNDS = 32,
    localparam int IDX_W = $clog2(ROUNDS)
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [127:0]       plain_i,
    output logic [IDX_W-1:0]   rk_idx_o,
    input  logic [31:0]        rk_i,
    output logic [127:0]       cipher_o,
    output logic               done_o
);
    state_t st;
    logic   load;
    logic   busy;
    word_t  sub_in;
    word_t  sub_out;
    word_t  lin_out;
    word_t  fresh;

    sm4c_seq #(.ROUNDS(ROUNDS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .load_o  (load),
        .busy_o  (busy),
        .idx_o   (rk_idx_o),
        .done_o  (done_o)
    );

    assign sub_in = st.w1 ^ st.w2 ^ st.w3 ^ rk_i;

    sm4c_tau #(.W(WORD_W)) u_tau (
        .x_i (sub_in),
        .y_o (sub_out)
    );

    sm4c_diffuse u_lin (
        .b_i (sub_out),
        .c_o (lin_out)
    );

    assign fresh = lin_out ^ st.w0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (load) begin
            st <= state_t'(plain_i);
        end else if (busy) begin
            st.w0 <= st.w1;
            st.w1 <= st.w2;
            st.w2 <= st.w3;
            st.w3 <= fresh;
        end
    end

    assign cipher_o = {st.w3, st.w2, st.w1, st.w0};

    p_ct_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start_i) |=> $stable(cipher_o));

    p_word_shift_r5: assert property (@(posedge clk) disable iff (rst)
        busy |=> (cipher_o[31:0] == $past(cipher_o[63:32])
                  && cipher_o[95:64] == $past(cipher_o[127:96])));

    p_load_order_r1: assert property (@(posedge clk) disable iff (rst)
        load |=> (cipher_o[127:96] == $past(plain_i[31:0])
                  && cipher_o[31:0] == $past(plain_i[127:96])));
endmodule

// File: tb/tb_sm4c_iter_core.sv
module tb_sm4c_iter_core;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [127:0] pt;
    logic [4:0]   rk_idx;
    logic [31:0]  rk;
    logic [127:0] ct;
    logic         done;

    logic [31:0] rk_mem [32];
    logic [7:0]  aes_tab [256];
    int n_chk = 0;
    int n_bad = 0;

    localparam logic [127:0] STD_VEC = 128'h0123456789abcdeffedcba9876543210;
    localparam logic [127:0] STD_CT  = 128'h681edf34d206965e86b3e94f536e4246;
    localparam logic [127:0] T_PLO = 128'hC7C1B4B222245157_9197E2E474720701;
    localparam logic [127:0] T_PHI = 128'hF052B91BF95BB012_E240AB09EB49A200;
    localparam logic [127:0] T_QLO = 128'hEDD14478172BBE82_5B67F2CEA19D0834;
    localparam logic [127:0] T_QHI = 128'h11CDBE62CC1063BF_AE7201DD73AFDC00;

    // {key, plaintext}
    localparam logic [255:0] VECS [4] = '{
        {STD_VEC, STD_VEC},
        {128'h0, 128'h0},
        {128'hffffffffffffffffffffffffffffffff, 128'h00112233445566778899aabbccddeeff},
        {128'h8000000000000000000000000000007f, 128'hdeadbeef0badf00dcafebabe12345678}
    };

    assign rk = rk_mem[rk_idx];

    sm4c_iter_core dut (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .plain_i  (pt),
        .rk_idx_o (rk_idx),
        .rk_i     (rk),
        .cipher_o (ct),
        .done_o   (done)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] tb_nib(input logic [127:0] t, input int n);
        return t[n*8 +: 8];
    endfunction

    function automatic logic [7:0] tb_sbox(input logic [7:0] b);
        logic [7:0] z;
        z = aes_tab[tb_nib(T_PLO, int'(b[3:0])) ^ tb_nib(T_PHI, int'(b[7:4]))];
        return tb_nib(T_QLO, int'(z[3:0])) ^ tb_nib(T_QHI, int'(z[7:4]));
    endfunction

    function automatic logic [31:0] tb_tau(input logic [31:0] w);
        return {tb_sbox(w[31:24]), tb_sbox(w[23:16]), tb_sbox(w[15:8]), tb_sbox(w[7:0])};
    endfunction

    function automatic logic [31:0] rl(input logic [31:0] w, input int n);
        return (w << n) | (w >> (32 - n));
    endfunction

    task automatic build_aes();
        logic [7:0] p;
        logic [7:0] q;
        logic [7:0] a;
        p = 8'h01;
        q = 8'h01;
        for (int k = 0; k < 255; k++) begin
            p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b00};
            q = q ^ {q[3:0], 4'b0000};
            if (q[7]) q = q ^ 8'h09;
            a = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
            aes_tab[p] = a ^ 8'h63;
        end
        aes_tab[0] = 8'h63;
    endtask

    task automatic expand_key(input logic [127:0] key);
        logic [31:0] kw [36];
        logic [31:0] fk [4];
        logic [31:0] ck;
        logic [31:0] b;
        fk[0] = 32'hA3B1BAC6; fk[1] = 32'h56AA3350;
        fk[2] = 32'h677D9197; fk[3] = 32'hB27022DC;
        for (int j = 0; j < 4; j++) kw[j] = key[127 - 32*j -: 32] ^ fk[j];
        for (int i = 0; i < 32; i++) begin
            for (int j = 0; j < 4; j++) ck[31 - 8*j -: 8] = 8'((4*i + j) * 7);
            b = tb_tau(kw[i+1] ^ kw[i+2] ^ kw[i+3] ^ ck);
            kw[i+4] = kw[i] ^ b ^ rl(b, 13) ^ rl(b, 23);
            rk_mem[i] = kw[i+4];
        end
    endtask

    function automatic logic [127:0] ref_enc(input logic [127:0] p);
        logic [31:0] x [4];
        logic [31:0] b;
        logic [31:0] nw;
        for (int j = 0; j < 4; j++) x[j] = p[127 - 32*j -: 32];
        for (int i = 0; i < 32; i++) begin
            b  = tb_tau(x[1] ^ x[2] ^ x[3] ^ rk_mem[i]);
            nw = x[0] ^ b ^ rl(b, 2) ^ rl(b, 10) ^ rl(b, 18) ^ rl(b, 24);
            x[0] = x[1]; x[1] = x[2]; x[2] = x[3]; x[3] = nw;
        end
        return {x[3], x[2], x[1], x[0]};
    endfunction

    // starts a block at a negedge; mid selects the round at which a second
    // start pulse with other data is injected (-1 for none)
    task automatic run_block(input logic [127:0] p, input logic [127:0] exp, input int mid);
        @(negedge clk);
        start = 1'b1;
        pt    = p;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 32; i++) begin
            chk("R2 round-key index", 128'(rk_idx), 128'(i));
            chk("R7 done low during rounds", 128'(done), 128'd0);
            if (i == mid) begin
                start = 1'b1;
                pt    = ~p;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        chk("R7 done after round 32", 128'(done), 128'd1);
        if (mid >= 0) chk("R8 ciphertext after ignored start", ct, exp);
        else          chk("R3 R4 R5 R6 ciphertext vs model", ct, exp);
        @(posedge clk);
        @(negedge clk);
        chk("R7 done lasts one cycle", 128'(done), 128'd0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] exp;
        logic [127:0] held;
        logic         seen;
        rst   = 1'b1;
        start = 1'b0;
        pt    = '0;
        for (int i = 0; i < 32; i++) rk_mem[i] = '0;
        build_aes();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset ciphertext", ct, 128'd0);
        chk("R10 reset done", 128'(done), 128'd0);
        chk("R10 reset index", 128'(rk_idx), 128'd0);
        chk("R3 S-box of zero", 128'(tb_sbox(8'h00)), 128'hD6);
        rst = 1'b0;

        for (int v = 0; v < 4; v++) begin
            expand_key(VECS[v][255:128]);
            exp = ref_enc(VECS[v][127:0]);
            if (v == 0) chk("R11 bench model standard vector", exp, STD_CT);
            run_block(VECS[v][127:0], exp, -1);
            if (v == 0) chk("R11 core standard vector", ct, STD_CT);
        end

        // R1 word order: a swapped-word plaintext gives another result
        expand_key(STD_VEC);
        exp = ref_enc({STD_VEC[31:0], STD_VEC[63:32], STD_VEC[95:64], STD_VEC[127:96]});
        run_block({STD_VEC[31:0], STD_VEC[63:32], STD_VEC[95:64], STD_VEC[127:96]}, exp, -1);
        chk("R1 word-swapped plaintext", ct, exp);

        // R8 start pulses during a block and during its last round
        expand_key(VECS[2][255:128]);
        exp = ref_enc(VECS[2][127:0]);
        run_block(VECS[2][127:0], exp, 10);
        run_block(VECS[2][127:0], exp, 31);

        // R9 output held after completion
        held = ct;
        for (int i = 0; i < 6; i++) begin
            pt = {4{32'(i * 32'h9E3779B9)}};
            @(posedge clk);
            @(negedge clk);
        end
        chk("R9 ciphertext held", ct, held);
        chk("R9 done stays low", 128'(done), 128'd0);

        // R10 reset in mid-block
        @(negedge clk);
        start = 1'b1;
        pt    = VECS[3][127:0];
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 mid-block reset ciphertext", ct, 128'd0);
        chk("R10 mid-block reset index", 128'(rk_idx), 128'd0);
        chk("R10 mid-block reset done", 128'(done), 128'd0);
        rst  = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        chk("R10 no done after aborted block", 128'(seen), 128'd0);

        // core still usable after the abort
        expand_key(STD_VEC);
        run_block(STD_VEC, STD_CT, -1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule